// File: doc/BRIEF.md
# Hot-Swap Insertion and Extraction Handshake Controller

This block carries the software side of the connection handshake on a hot-swappable add-in board. It watches the injector handle micro-switch, the host's active-low board-select line and the active-low local reset coming from the board's power sequencer. From these it drives the blue "safe to remove" LED and the open-drain service request line that calls the host's hot-plug driver. Two status bits record why service was requested: one for a fresh insertion, one for a pending extraction. The host clears each bit by writing a one to it.

On insertion the LED is lit by hardware from reset. It stays lit until the host has selected the board and the power sequencer has released local reset. Closing the injector handle after that raises an insertion request. The operator starts a removal by opening the handle, which raises an extraction request. The operator then waits for host software to light the LED through its LED-on control before pulling the board. The raw switch passes through a synchronizer and a debounce filter, so contact bounce cannot raise a request.

Top module: `hs_insert_handshake`

## Requirements
- R1: While rst_n is sampled low, ins_pend, ext_pend and enum_oe read 0 and led_on reads 1.
- R2: led_on is 1 one clock after local_rst_n is sampled 0, whatever the other inputs are.
- R3: led_on is 1 one clock after host_sel_n is sampled 1, whatever the other inputs are.
- R4: With host_sel_n = 0, local_rst_n = 1 and host_led_on = 0, led_on is 0 one clock later.
- R5: host_led_on = 1 makes led_on 1 one clock later, whatever the other inputs are.
- R6: A 0-to-1 change of inject_sw_raw (1 = handle closed) that is held while the board is online (host_sel_n = 0 and local_rst_n = 1) sets ins_pend at the (DEB_CYC+3)-th rising clock edge after the change and not before.
- R7: A held 1-to-0 change of inject_sw_raw (handle opened) while the board is online sets ext_pend, with the same latency as R6.
- R8: Switch changes that complete while the board is not online set neither status bit.
- R9: An inject_sw_raw pulse that lasts fewer than DEB_CYC-1 clock cycles and then returns to its old level sets neither status bit.
- R10: enum_oe (1 = pull the request line low) is 1 exactly when ins_pend or ext_pend is 1.
- R11: A clock with stat_clr_we = 1 clears ins_pend when stat_clr_mask bit 0 is 1 and clears ext_pend when bit 1 is 1. A mask bit of 0 leaves its status bit unchanged.
- R12: If a status bit is set and cleared on the same clock edge, the set wins and the bit reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inject_sw_raw | input | 1 | Raw injector micro-switch, 1 = handle closed, may bounce |
| host_sel_n | input | 1 | Host board-select, 0 = board selected |
| local_rst_n | input | 1 | Local reset from the power sequencer, 0 = in reset |
| host_led_on | input | 1 | Host control that lights the LED to allow extraction |
| stat_clr_we | input | 1 | Host write strobe to the status clear |
| stat_clr_mask | input | 2 | Write-one-to-clear mask: bit 0 insertion, bit 1 extraction |
| enum_oe | output | 1 | Open-drain enable for the service request line, 1 = drive low |
| led_on | output | 1 | Blue LED drive, 1 = lit |
| ins_pend | output | 1 | Insertion request pending |
| ext_pend | output | 1 | Extraction request pending |

## Verification
The assertions assume that host_sel_n, local_rst_n, host_led_on and the clear inputs are synchronous to clk. They assume the host write strobe is a single-cycle level, and that the online condition does not change while a switch change is still moving through the filter. The stimulus changes those inputs only at falling edges and between switch operations. After every switch change it waits at least DEB_CYC+6 cycles, and it makes glitches deliberately shorter than the filter window. The set-against-clear collision is placed on the exact edge at which the filter output lands.

// File: rtl/hs_pkg.sv
// Shared constants for the hot-swap handshake controller.
// Assumes: status bit order is fixed and shared with the host clear mask.
package hs_pkg;
    localparam int N_PEND      = 2;
    localparam int PEND_INS    = 0;
    localparam int PEND_EXT    = 1;
    localparam int DEB_DEFAULT = 16;
endpackage

// File: rtl/hs_sw_filter.sv
// Injector switch conditioner: two-stage synchronizer, then a debounce
// filter that accepts a new level only after DEB_CYC consecutive samples
// of it, then edge pulses on the filtered level.
// Assumes: DEB_CYC >= 2; switch reads 0 (open) out of reset.
module hs_sw_filter #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw_i,
    output logic close_o,
    output logic open_o
);
    localparam int CW = (DEB_CYC > 2) ? $clog2(DEB_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

    logic          sync1_q, sync2_q;
    logic          deb_q, deb_prev_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous switch into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= sw_raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Count consecutive disagreeing samples; adopt the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb_q <= 1'b0;
            cnt_q <= '0;
        end else if (sync2_q == deb_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            deb_q <= sync2_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) deb_prev_q <= 1'b0;
        else        deb_prev_q <= deb_q;
    end

    assign close_o = deb_q & ~deb_prev_q;
    assign open_o  = ~deb_q & deb_prev_q;

    // A synchronized sample equal to the filtered level never moves it.
    assert_deb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_q == deb_q) |=> $stable(deb_q));

    // Filtered level only moves toward the synchronized sample.
    assert_deb_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deb_q) |-> (deb_q == $past(sync2_q)));
endmodule

// File: rtl/hs_pend_bit.sv
// One request status bit: set by a pulse, cleared by a host
// write-one-to-clear; a set on the same edge overrides the clear.
// Assumes: set_i and clr_i are single-cycle qualified strobes.
module hs_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;

    // Hold the request until the host acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (set_i)  pend_q <= 1'b1;
        else if (clr_i)  pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q);

    assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_q);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> !$rose(pend_q));
endmodule

// File: rtl/hs_led_ctl.sv
// Blue LED driver: lit while the board is not yet online (local reset
// active or not selected by the host) or when host software asks for it.
// Assumes: all inputs synchronous to clk; lit out of reset.
module hs_led_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic host_sel_n_i,
    input  logic local_rst_n_i,
    input  logic host_led_on_i,
    output logic led_o
);
    logic led_q;

    // Register the LED term so the pad sees a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n) led_q <= 1'b1;
        else        led_q <= !local_rst_n_i || host_sel_n_i || host_led_on_i;
    end

    assign led_o = led_q;

    assert_led_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !local_rst_n_i |=> led_q);

    assert_led_unsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel_n_i |=> led_q);

    assert_led_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_led_on_i |=> led_q);
endmodule

// File: rtl/hs_insert_handshake.sv
// Hot-swap insertion/extraction handshake top level. Filters the injector
// switch, raises insertion or extraction requests on filtered handle
// transitions while the board is online, drives the open-drain request
// enable and the blue extraction LED.
// Assumes: host-side inputs are synchronous to clk; reset is synchronous.
module hs_insert_handshake
    import hs_pkg::*;
#(
    parameter int DEB_CYC = DEB_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject_sw_raw,
    input  logic              host_sel_n,
    input  logic              local_rst_n,
    input  logic              host_led_on,
    input  logic              stat_clr_we,
    input  logic [N_PEND-1:0] stat_clr_mask,
    output logic              enum_oe,
    output logic              led_on,
    output logic              ins_pend,
    output logic              ext_pend
);
    logic              sw_close, sw_open, online;
    logic [N_PEND-1:0] set_vec, clr_vec, pend_vec;

    hs_sw_filter #(.DEB_CYC(DEB_CYC)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_raw_i (inject_sw_raw),
        .close_o  (sw_close),
        .open_o   (sw_open)
    );

    // Requests are only meaningful once selected and powered.
    assign online            = !host_sel_n && local_rst_n;
    assign set_vec[PEND_INS] = sw_close && online;
    assign set_vec[PEND_EXT] = sw_open  && online;
    assign clr_vec           = stat_clr_we ? stat_clr_mask : '0;

    for (genvar i = 0; i < N_PEND; i++) begin : g_pend
        hs_pend_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .pend_o (pend_vec[i])
        );
    end

    hs_led_ctl u_led (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_sel_n_i  (host_sel_n),
        .local_rst_n_i (local_rst_n),
        .host_led_on_i (host_led_on),
        .led_o         (led_on)
    );

    assign ins_pend = pend_vec[PEND_INS];
    assign ext_pend = pend_vec[PEND_EXT];
    assign enum_oe  = |pend_vec;

    // Offline switch activity never raises a request.
    assert_offline_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !online |=> !$rose(ins_pend) && !$rose(ext_pend));

    // The two filtered edges never coincide.
    assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_close, sw_open}));

    // The request line releases once both bits are cleared without a set.
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_we && (&stat_clr_mask) && !sw_close && !sw_open) |=> !enum_oe);
endmodule

// File: tb/sim_hs_insert_handshake.sv
module sim_hs_insert_handshake;
    localparam int DEB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_raw = 1'b0, sel_n = 1'b1, lrst_n = 1'b0, led_sw = 1'b0;
    logic       clr_we = 1'b0;
    logic [1:0] clr_mask = 2'b00;
    logic       enum_oe, led_on, ins_pend, ext_pend;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    bit m_sw = 0, m_ins = 0, m_ext = 0;

    always #5 clk = ~clk;

    hs_insert_handshake #(.DEB_CYC(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .inject_sw_raw(sw_raw), .host_sel_n(sel_n),
        .local_rst_n(lrst_n), .host_led_on(led_sw), .stat_clr_we(clr_we),
        .stat_clr_mask(clr_mask), .enum_oe(enum_oe), .led_on(led_on),
        .ins_pend(ins_pend), .ext_pend(ext_pend)
    );

    function automatic bit exp_led(bit s_n, bit l_n, bit h);
        return (!l_n) || s_n || h;
    endfunction

    function automatic bit is_online(bit s_n, bit l_n);
        return !s_n && l_n;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " led R2/R3/R4/R5"}, led_on, exp_led(sel_n, lrst_n, led_sw));
        check({tag, " ins R6/R8/R11"}, ins_pend, m_ins);
        check({tag, " ext R7/R8/R11"}, ext_pend, m_ext);
        check({tag, " enum R10"}, enum_oe, m_ins | m_ext);
    endtask

    task automatic sw_move(bit lvl);
        sw_raw = lvl;
        step(DEB + 6);
        if (lvl != m_sw && is_online(sel_n, lrst_n)) begin
            if (lvl) m_ins = 1;
            else     m_ext = 1;
        end
        m_sw = lvl;
    endtask

    task automatic host_clear(logic [1:0] mask);
        clr_we = 1'b1;
        clr_mask = mask;
        step(1);
        clr_we = 1'b0;
        clr_mask = 2'b00;
        if (mask[0]) m_ins = 0;
        if (mask[1]) m_ext = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        step(3);
        // R1: reset state
        check("R1 led", led_on, 1'b1);
        check("R1 ins", ins_pend, 1'b0);
        check("R1 ext", ext_pend, 1'b0);
        check("R1 enum", enum_oe, 1'b0);
        rst_n = 1'b1;
        step(1);

        sel_n = 0; lrst_n = 0; step(1);
        check("R2 led in local reset", led_on, 1'b1);
        sel_n = 1; lrst_n = 1; step(1);
        check("R3 led unselected", led_on, 1'b1);
        sel_n = 0; lrst_n = 1; step(1);
        check("R4 led dark online", led_on, 1'b0);
        led_sw = 1; step(1);
        check("R5 led host on", led_on, 1'b1);
        led_sw = 0; step(1);
        check("R4 led dark again", led_on, 1'b0);

        // R6 exact latency, R12 collision on the landing edge
        sw_raw = 1;
        step(DEB + 2);
        check("R6 not yet set", ins_pend, 1'b0);
        clr_we = 1; clr_mask = 2'b01;
        step(1);
        clr_we = 0; clr_mask = 2'b00;
        m_sw = 1; m_ins = 1;
        check("R6 R12 set wins over clear", ins_pend, 1'b1);
        check("R10 enum with ins", enum_oe, 1'b1);

        host_clear(2'b01);
        check("R11 ins cleared", ins_pend, 1'b0);
        check("R10 enum released", enum_oe, 1'b0);

        sw_move(0);
        check("R7 ext set on open", ext_pend, 1'b1);
        check("R7 ins untouched", ins_pend, 1'b0);

        host_clear(2'b01);
        check("R11 ext kept by mask bit0", ext_pend, 1'b1);
        host_clear(2'b10);
        check("R11 ext cleared by mask bit1", ext_pend, 1'b0);

        sel_n = 1; step(1);
        sw_move(1);
        check("R8 offline close ignored", ins_pend, 1'b0);
        sw_move(0);
        check("R8 offline open ignored", ext_pend, 1'b0);
        sel_n = 0; lrst_n = 0; step(1);
        sw_move(1);
        check("R8 in reset close ignored", ins_pend, 1'b0);
        sw_move(0);
        lrst_n = 1; step(1);

        sw_raw = 1; step(DEB - 2);
        sw_raw = 0; step(DEB + 6);
        check("R9 glitch ignored ins", ins_pend, 1'b0);
        check("R9 glitch ignored enum", enum_oe, 1'b0);
        check_all("directed");

        // constrained random phase
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0, 1: sw_move(!m_sw);
                2: begin
                    int w;
                    w = int'($urandom_range(1, DEB - 2));
                    sw_raw = !m_sw; step(w);
                    sw_raw = m_sw;  step(DEB + 6);
                end
                3: begin
                    sel_n  = ($urandom_range(0, 3) == 0);
                    lrst_n = ($urandom_range(0, 3) != 0);
                    step(2);
                end
                4: host_clear(2'($urandom_range(0, 3)));
                default: begin
                    led_sw = $urandom_range(0, 1);
                    step(1);
                end
            endcase
            check_all("random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule